// File: doc/BRIEF.md
# PCM Serial Receive Port

This block takes one voice sample per frame from a serial data line and presents it as a parallel word with a single-cycle valid pulse. A frame sync marks the time slot. Each word is either an 8-bit companded code, passed through unchanged for a later expander, or a 16-bit linear word. A linear word carries a 13-bit two's-complement sample and a 3-bit attenuation code, and the port scales the sample down in 3 dB steps before presenting it.

Everything runs on one fast system clock. The serial bit clock is an input that the block oversamples: it watches for falling transitions. In fixed-rate mode the bit clock is the master clock, and the sync is a start pulse. In variable-rate mode the bit clock is a separate receive clock, and the sync stays high for the whole slot. The two modes take the bits from different positions within the slot. The attenuation code travels inside every linear word and affects only that word.

Top module: `pcm_rx_port`

## Requirements
- R1: Serial bits and the sync level are taken only at falling transitions of the selected bit clock. `rate_var`=0 selects `mclk`, and `rate_var`=1 selects `rclk`. Transitions of the other clock have no effect.
- R2: Fixed-rate mode. A word starts at the first falling edge at which `fsync` is high while no word is in progress, and that edge captures the first bit. Each of the following falling edges captures one more bit until the word has 8 bits (companded) or 16 bits (linear). The level of `fsync` has no effect until the word is complete.
- R3: Variable-rate mode. A bit is shifted in at each falling edge while `fsync` is high. The slot closes at the first falling edge with `fsync` low. The word is made of the last 8 (companded) or last 16 (linear) bits of the slot. A slot with fewer bits than that produces no output.
- R4: The first received bit is the most significant bit. For a linear word, the first 13 received bits form the two's-complement sample, MSB first, and the last 3 bits form the attenuation code, MSB first.
- R5: The linear output is round((sample × G[code]) / 16384), rounded half toward plus infinity and then clamped to −4096..4095. The gains G for codes 0 to 7 are 16384, 11599, 8211, 5813, 4115, 2914, 2063 and 1460, which is 3 dB more attenuation per code step, from 0 dB to 21 dB. Code 0 returns the sample unchanged, and a non-negative sample never yields a negative output.
- R6: The attenuation code is not held between words. Each word is scaled only by its own code, and `lin_vol` shows the code of the word being presented.
- R7: In companded mode, `comp_code` carries the 8 received bits, the first received bit at bit 7, and `lin_sample` and `lin_vol` are zero. In linear mode, `comp_code` is zero.
- R8: `word_valid` is high for exactly one system clock per completed word, and the data outputs hold their values until the next word.
- R9: After reset, all outputs are zero and no word is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clocks |
| rst | input | 1 | Synchronous active-high reset |
| rate_var | input | 1 | 0 = fixed-rate mode on `mclk`, 1 = variable-rate mode on `rclk` |
| fmt_lin | input | 1 | 0 = 8-bit companded word, 1 = 16-bit linear word |
| mclk | input | 1 | Master clock, used as the bit clock in fixed-rate mode |
| rclk | input | 1 | Receive bit clock for variable-rate mode |
| fsync | input | 1 | Receive frame sync |
| sdata | input | 1 | Serial data input |
| word_valid | output | 1 | One-cycle pulse per completed word |
| comp_code | output | 8 | Received companded code |
| lin_sample | output | 13 | Attenuated two's-complement linear sample |
| lin_vol | output | 3 | Attenuation code of the presented word |

## Verification
The close of a variable-rate slot and the capture of a new bit both depend on the same falling edge. At that edge the block decides, from the sync level alone, whether it shifts in one more bit or releases the word built from the bits already in the register. The bench provokes both outcomes. It sends slots longer than a word, which must discard their earliest bits, and slots shorter than a word, which must produce no pulse at all. Every result is judged by comparing the presented word with the trailing bits computed in the bench. The decode of the attenuation code and the scaling multiply also act on the same word in the same cycle. The bench covers every code against samples at both range limits and around zero, with each expected value computed as the rounded product.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    localparam int SAMPLE_W  = 13;
    localparam int VOL_W     = 3;
    localparam int LIN_W     = SAMPLE_W + VOL_W;
    localparam int COMP_W    = 8;
    localparam int GAIN_FRAC = 14;
    localparam int GAIN_W    = GAIN_FRAC + 1;
    localparam int CNT_W     = $clog2(LIN_W + 1);
    localparam int PROD_W    = SAMPLE_W + GAIN_W + 1;

    typedef enum logic {RATE_FIXED = 1'b0, RATE_VAR = 1'b1} rate_e;
    typedef enum logic {FMT_COMP = 1'b0, FMT_LIN = 1'b1} fmt_e;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] smp;
        logic [VOL_W-1:0]           vol;
    } lin_word_t;

    // Q1.14 gain, 3 dB per step
    function automatic logic [GAIN_W-1:0] gain_of(input logic [VOL_W-1:0] k);
        logic [GAIN_W-1:0] g;
        case (k)
            3'd0:    g = GAIN_W'(16384);
            3'd1:    g = GAIN_W'(11599);
            3'd2:    g = GAIN_W'(8211);
            3'd3:    g = GAIN_W'(5813);
            3'd4:    g = GAIN_W'(4115);
            3'd5:    g = GAIN_W'(2914);
            3'd6:    g = GAIN_W'(2063);
            default: g = GAIN_W'(1460);
        endcase
        return g;
    endfunction

    function automatic logic signed [SAMPLE_W-1:0] clamp_sample(input logic signed [PROD_W-1:0] v);
        logic signed [PROD_W-1:0] hi;
        logic signed [PROD_W-1:0] lo;
        hi = PROD_W'((1 << (SAMPLE_W - 1)) - 1);
        lo = -PROD_W'(1 << (SAMPLE_W - 1));
        if (v > hi)
            return hi[SAMPLE_W-1:0];
        else if (v < lo)
            return lo[SAMPLE_W-1:0];
        else
            return v[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/pcm_rx_edge.sv
module pcm_rx_edge
    import pcm_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rate_var,
    input  logic mclk,
    input  logic rclk,
    input  logic fs_in,
    input  logic sd_in,
    output logic fall,
    output logic fs_s,
    output logic sd_s
);

    logic bclk_s;
    logic bclk_d;
    logic bclk_sel;

    // pick the bit clock for the mode
    assign bclk_sel = (rate_e'(rate_var) == RATE_VAR) ? rclk : mclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_s <= 1'b0;
            bclk_d <= 1'b0;
            fs_s   <= 1'b0;
            sd_s   <= 1'b0;
        end else begin
            bclk_s <= bclk_sel;
            bclk_d <= bclk_s;
            fs_s   <= fs_in;
            sd_s   <= sd_in;
        end
    end

    // sync and data registered in the same stage as the clock sample
    assign fall = bclk_d & ~bclk_s;

    AST_FALL_SPACED: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall); // R1

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
    import pcm_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rate_var,
    input  logic             fmt_lin,
    input  logic             fall,
    input  logic             fs,
    input  logic             sd,
    output logic             done,
    output logic [LIN_W-1:0] word
);

    logic [CNT_W-1:0] cnt;
    logic             active;
    logic [CNT_W-1:0] nbits;
    logic [LIN_W-1:0] shifted;

    assign nbits   = (fmt_e'(fmt_lin) == FMT_LIN) ? CNT_W'(LIN_W) : CNT_W'(COMP_W);
    assign shifted = {word[LIN_W-2:0], sd};

    always_ff @(posedge clk) begin
        if (rst) begin
            word   <= '0;
            cnt    <= '0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (fall) begin
                if (rate_e'(rate_var) == RATE_FIXED) begin
                    // fixed rate: sync starts a word of fixed length
                    if (!active) begin
                        if (fs) begin
                            word   <= shifted;
                            cnt    <= CNT_W'(1);
                            active <= 1'b1;
                        end
                    end else begin
                        word <= shifted;
                        if (cnt + CNT_W'(1) == nbits) begin
                            cnt    <= '0;
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end else begin
                    // variable rate: sync level frames the slot, keep trailing bits
                    if (fs) begin
                        word   <= shifted;
                        active <= 1'b1;
                        if (cnt != CNT_W'(LIN_W))
                            cnt <= cnt + CNT_W'(1);
                    end else if (active) begin
                        active <= 1'b0;
                        cnt    <= '0;
                        if (cnt >= nbits)
                            done <= 1'b1;
                    end
                end
            end
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(LIN_W)); // R3

    AST_DONE_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(fall)); // R2

endmodule

// File: rtl/pcm_rx_atten.sv
module pcm_rx_atten
    import pcm_rx_pkg::*;
(
    input  logic signed [SAMPLE_W-1:0] smp,
    input  logic [VOL_W-1:0]           code,
    output logic signed [SAMPLE_W-1:0] y
);

    logic [GAIN_W-1:0]        gain;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rnd;
    logic signed [PROD_W-1:0] scaled;

    assign gain   = gain_of(code);
    assign prod   = PROD_W'(smp) * PROD_W'($signed({1'b0, gain}));
    assign rnd    = prod + PROD_W'(1 << (GAIN_FRAC - 1));
    assign scaled = rnd >>> GAIN_FRAC;
    assign y      = clamp_sample(scaled);

endmodule

// File: rtl/pcm_rx_port.sv
module pcm_rx_port
    import pcm_rx_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rate_var,
    input  logic                       fmt_lin,
    input  logic                       mclk,
    input  logic                       rclk,
    input  logic                       fsync,
    input  logic                       sdata,
    output logic                       word_valid,
    output logic [COMP_W-1:0]          comp_code,
    output logic signed [SAMPLE_W-1:0] lin_sample,
    output logic [VOL_W-1:0]           lin_vol
);

    logic             fall;
    logic             fs_s;
    logic             sd_s;
    logic             done;
    logic [LIN_W-1:0] word;
    lin_word_t        lw;
    logic signed [SAMPLE_W-1:0] att;

    pcm_rx_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .rate_var (rate_var),
        .mclk     (mclk),
        .rclk     (rclk),
        .fs_in    (fsync),
        .sd_in    (sdata),
        .fall     (fall),
        .fs_s     (fs_s),
        .sd_s     (sd_s)
    );

    pcm_rx_deser u_deser (
        .clk      (clk),
        .rst      (rst),
        .rate_var (rate_var),
        .fmt_lin  (fmt_lin),
        .fall     (fall),
        .fs       (fs_s),
        .sd       (sd_s),
        .done     (done),
        .word     (word)
    );

    assign lw = lin_word_t'(word);

    pcm_rx_atten u_atten (
        .smp  (lw.smp),
        .code (lw.vol),
        .y    (att)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_valid <= 1'b0;
            comp_code  <= '0;
            lin_sample <= '0;
            lin_vol    <= '0;
        end else begin
            word_valid <= done;
            if (done) begin
                if (fmt_e'(fmt_lin) == FMT_LIN) begin
                    lin_sample <= att;
                    lin_vol    <= lw.vol;
                    comp_code  <= '0;
                end else begin
                    lin_sample <= '0;
                    lin_vol    <= '0;
                    comp_code  <= word[COMP_W-1:0];
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid); // R8

    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (rst)
        (word_valid && $past(fmt_lin) && lin_vol == '0) |-> (lin_sample == $past(lw.smp))); // R5

    AST_NO_SIGN_FLIP: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !$past(word[LIN_W-1])) |-> !lin_sample[SAMPLE_W-1]); // R5

endmodule

// File: tb/sim_pcm_rx_port.sv
`timescale 1ns/1ps
module sim_pcm_rx_port;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate_var = 1'b0;
    logic fmt_lin = 1'b0;
    logic mclk = 1'b0;
    logic rclk = 1'b0;
    logic fsync = 1'b0;
    logic sdata = 1'b0;
    logic word_valid;
    logic [7:0] comp_code;
    logic signed [12:0] lin_sample;
    logic [2:0] lin_vol;

    int n_chk = 0;
    int n_bad = 0;
    int vcnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pcm_rx_port u0 (
        .clk(clk), .rst(rst), .rate_var(rate_var), .fmt_lin(fmt_lin),
        .mclk(mclk), .rclk(rclk), .fsync(fsync), .sdata(sdata),
        .word_valid(word_valid), .comp_code(comp_code),
        .lin_sample(lin_sample), .lin_vol(lin_vol)
    );

    always @(negedge clk) if (!rst && word_valid) vcnt++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_att(input int s, input int k);
        int g[8] = '{16384, 11599, 8211, 5813, 4115, 2914, 2063, 1460};
        int r;
        r = (s * g[k] + 8192) >>> 14;
        if (r > 4095) r = 4095;
        if (r < -4096) r = -4096;
        return r;
    endfunction

    // one bit period: data changes while the clock is high, other clock pulses as a decoy
    task automatic tick(input bit b, input bit f);
        @(negedge clk);
        sdata = b; fsync = f;
        if (rate_var) rclk = 1'b1; else mclk = 1'b1;
        @(negedge clk);
        if (rate_var) mclk = 1'b1; else rclk = 1'b1;
        @(negedge clk);
        if (rate_var) mclk = 1'b0; else rclk = 1'b0;
        repeat (2) @(negedge clk);
        if (rate_var) rclk = 1'b0; else mclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_fixed(input logic [15:0] w, input int n, input bit fs_hold);
        for (int i = 0; i < n; i++) tick(w[n-1-i], (i == 0) || fs_hold);
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);
    endtask

    task automatic send_var(input logic [31:0] w, input int len);
        for (int i = 0; i < len; i++) tick(w[len-1-i], 1'b1);
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int smp[12] = '{-4096, -4095, -2048, -1, 0, 1, 2, 3, 2047, 4095, 1234, -777};
        int v0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(word_valid == 0, "R9 valid", word_valid, 0);
        chk(comp_code == 0, "R9 comp", comp_code, 0);
        chk(lin_sample == 0, "R9 sample", lin_sample, 0);
        chk(lin_vol == 0, "R9 vol", lin_vol, 0);

        // R2 R4 R5 R6: fixed-rate linear sweep over all codes
        fmt_lin = 1'b1; rate_var = 1'b0;
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 12; j++) begin
                logic [12:0] s13;
                s13 = 13'(smp[j]);
                v0 = vcnt;
                send_fixed({s13, 3'(k)}, 16, 1'b0);
                chk(vcnt - v0 == 1, "R8 one pulse", vcnt - v0, 1);
                chk(lin_sample == 13'(exp_att(smp[j], k)), "R5 scaled", lin_sample, exp_att(smp[j], k));
                chk(lin_vol == 3'(k), "R6 vol", lin_vol, k);
                chk(comp_code == 0, "R7 comp zero", comp_code, 0);
            end
        end

        // R6: code 5 then code 0, second word is not attenuated
        send_fixed({13'(1000), 3'd5}, 16, 1'b0);
        send_fixed({13'(1000), 3'd0}, 16, 1'b0);
        chk(lin_sample == 1000, "R6 no latch", lin_sample, 1000);

        // R2: sync held high through the whole word is ignored after the start
        v0 = vcnt;
        send_fixed({13'(-300), 3'd2}, 16, 1'b1);
        chk(vcnt - v0 == 1, "R2 sync ignored", vcnt - v0, 1);
        chk(lin_sample == 13'(exp_att(-300, 2)), "R2 word", lin_sample, exp_att(-300, 2));

        // R7 R1: fixed-rate companded, all codes
        fmt_lin = 1'b0;
        for (int c = 0; c < 256; c++) begin
            v0 = vcnt;
            send_fixed(16'(c), 8, 1'b0);
            chk(vcnt - v0 == 1, "R8 comp pulse", vcnt - v0, 1);
            chk(comp_code == 8'(c), "R7 comp", comp_code, c);
            chk(lin_sample == 0 && lin_vol == 0, "R7 lin zero", lin_sample, 0);
        end

        // R3 R1: variable-rate companded, long slot keeps trailing 8 bits
        rate_var = 1'b1;
        v0 = vcnt;
        send_var(32'h5A7, 11);
        chk(vcnt - v0 == 1, "R3 long slot", vcnt - v0, 1);
        chk(comp_code == 8'hA7, "R3 trailing bits", comp_code, 8'hA7);
        v0 = vcnt;
        send_var(32'h3C, 8);
        chk(comp_code == 8'h3C, "R3 exact slot", comp_code, 8'h3C);
        // R3: short slot produces nothing, outputs unchanged
        v0 = vcnt;
        send_var(32'h15, 6);
        chk(vcnt - v0 == 0, "R3 short slot", vcnt - v0, 0);
        chk(comp_code == 8'h3C, "R3 held", comp_code, 8'h3C);

        // R3 R4 R5: variable-rate linear, 18-bit slot keeps last 16
        fmt_lin = 1'b1;
        v0 = vcnt;
        send_var({14'd0, 2'b11, 13'(-2000), 3'd3}, 18);
        chk(vcnt - v0 == 1, "R3 lin pulse", vcnt - v0, 1);
        chk(lin_sample == 13'(exp_att(-2000, 3)), "R4 lin var", lin_sample, exp_att(-2000, 3));
        chk(lin_vol == 3'd3, "R4 vol var", lin_vol, 3);
        send_var({16'd0, 13'(4095), 3'd7}, 16);
        chk(lin_sample == 13'(exp_att(4095, 7)), "R5 var max", lin_sample, exp_att(4095, 7));

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule